// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block sits beside a 16-bit core. It looks at pending interrupt sources only when the core signals that an instruction has finished. When one source wins, it performs the whole entry sequence on a memory port that it shares with the core. It saves the old flags, code segment and instruction pointer on the stack and clears the interrupt-enable and trap bits. It then reads the new instruction pointer and code segment from the vector table at the bottom of memory. A one-cycle `done` pulse tells the core that the new values on `new_sp`, `new_cs`, `new_ip` and `new_flags` are ready to load.

There are five kinds of source: a divide fault, a software interrupt that brings its own type number, a non-maskable request, a maskable request, and single-step. The maskable request is gated by the interrupt-enable bit. Single-step is taken when the trap bit is set. For a maskable request the block raises an acknowledge and waits for the requester to present its 8-bit type before it touches memory. The non-maskable input is edge-detected and held until it is serviced.

The memory port is a valid/ready request channel. A request (`mem_valid`) stays asserted, with its address, write enable and write data unchanged, until `mem_ready` is high at a clock edge. Read data comes back on `mem_rsp_valid`/`mem_rdata` some cycles after the read request is accepted. The block always accepts read data and applies no back-pressure on that path.

Top module: `irq_entry_seq`

## Requirements
- R1: A new entry starts only on a clock edge where `boundary` is 1. Pending requests that are present while `boundary` is 0 start no memory traffic and no acknowledge.
- R2: When several sources are present at the same boundary, exactly one is taken. The order, highest first, is: divide fault, software interrupt, non-maskable, maskable, single-step.
- R3: A maskable request is taken only when interrupt-enable (bit 9 of `flags_in`) is 1. Otherwise it is ignored: no acknowledge and no entry.
- R4: The block makes three 16-bit stack writes, in this order: the original flags to SS·16+(SP−2), CS to SS·16+(SP−4), and IP to SS·16+(SP−6). The 16-bit offsets wrap, and the 20-bit physical address wraps.
- R5: `new_flags` equals the pushed flags with bit 9 (interrupt-enable) and bit 8 (trap) cleared. All other bits are unchanged.
- R6: After the pushes, the block reads the word at type·4 into `new_ip` and then the word at type·4+2 into `new_cs`.
- R7: The type numbers are: 0 for the divide fault, 1 for single-step (taken when bit 8 of `flags_in` is 1), 2 for non-maskable, and `swi_type` for a software interrupt (for example 3 for a breakpoint). Any value from 0 to 255 is accepted.
- R8: For a maskable request, `inta` stays high until `intr_type_valid` is 1. The `intr_type` present in that cycle becomes the type, and no memory request is made while `inta` is high.
- R9: A rising edge on `nmi` is remembered until a non-maskable entry is taken, even if the pulse ends or comes while an entry is in progress. A level that stays high does not cause a second entry.
- R10: A memory request holds `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ready` is seen. Any number of stall cycles gives the same result.
- R11: `done` is high for exactly one cycle at the end of an entry. In that cycle `new_sp` equals SP−6.
- R12: After reset, `busy`, `done`, `inta` and `mem_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction has finished; sources may be sampled |
| div_fault | input | 1 | Divide fault request |
| swi_req | input | 1 | Software interrupt request |
| swi_type | input | 8 | Type number of the software interrupt |
| nmi | input | 1 | Non-maskable request, edge-sensitive |
| intr | input | 1 | Maskable request, level |
| inta | output | 1 | Acknowledge to the maskable requester |
| intr_type_valid | input | 1 | Requester presents its type |
| intr_type | input | 8 | Type number from the requester |
| sp_in | input | 16 | Current stack pointer |
| ss_in | input | 16 | Current stack segment |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Return instruction pointer |
| flags_in | input | 16 | Current flags |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a word write |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Entry in progress |
| done | output | 1 | Entry complete; new values valid |
| new_sp | output | 16 | Stack pointer after the pushes |
| new_cs | output | 16 | Code segment from the vector |
| new_ip | output | 16 | Instruction pointer from the vector |
| new_flags | output | 16 | Flags with interrupt-enable and trap cleared |

## Verification
The assertions assume three things about the environment. The memory returns exactly one `mem_rsp_valid` pulse for each accepted read, and none at other times. The requester raises `intr_type_valid` only while `inta` is high. The core keeps the sources and the register values steady in the boundary cycle. The stimulus follows these rules. The bench memory model answers each accepted read one cycle later. The type responder raises `intr_type_valid` for one cycle, only in reply to `inta`. Inputs change only on the falling clock edge. Stall cycles come from a `mem_ready` that toggles, and they are applied to every kind of request.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IE_BIT = 9;
  localparam int TR_BIT = 8;
  localparam logic [7:0] TYPE_DIV  = 8'd0;
  localparam logic [7:0] TYPE_STEP = 8'd1;
  localparam logic [7:0] TYPE_NMI  = 8'd2;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_DIV, SRC_SWI, SRC_NMI, SRC_INTR, SRC_STEP
  } src_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ACK, ST_PUSH_F, ST_PUSH_CS, ST_PUSH_IP,
    ST_RD_IP, ST_W_IP, ST_RD_CS, ST_W_CS, ST_DONE
  } st_e;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic take,
  output logic pending
);
  logic prev;
  logic edge_seen;

  assign edge_seen = nmi_in & ~prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev    <= 1'b0;
      pending <= 1'b0;
    end else begin
      prev    <= nmi_in;
      pending <= edge_seen | (pending & ~take);
    end
  end

  // R9: a rising edge is always remembered
  a_r9_edge_held: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_in) |=> pending);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int TYPE_W = 8
) (
  input  logic              div_fault,
  input  logic              swi_req,
  input  logic [TYPE_W-1:0] swi_type,
  input  logic              nmi_pend,
  input  logic              intr,
  input  logic              ie_flag,
  input  logic              tr_flag,
  output src_e              src,
  output logic [TYPE_W-1:0] src_type
);
  always_comb begin
    src      = SRC_NONE;
    src_type = '0;
    if (div_fault) begin
      src      = SRC_DIV;
      src_type = TYPE_W'(TYPE_DIV);
    end else if (swi_req) begin
      src      = SRC_SWI;
      src_type = swi_type;
    end else if (nmi_pend) begin
      src      = SRC_NMI;
      src_type = TYPE_W'(TYPE_NMI);
    end else if (intr && ie_flag) begin
      src      = SRC_INTR;
      src_type = '0;
    end else if (tr_flag) begin
      src      = SRC_STEP;
      src_type = TYPE_W'(TYPE_STEP);
    end
  end

  // R2: a fault always wins over everything else
  a_r2_fault_first: assert final (!div_fault || src == SRC_DIV);
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int TYPE_W    = 8,
  parameter int SEG_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  src_e              src,
  input  logic [TYPE_W-1:0] src_type,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] ss_in,
  input  logic [DATA_W-1:0] cs_in,
  input  logic [DATA_W-1:0] ip_in,
  input  logic [DATA_W-1:0] flags_in,
  output logic              take,
  output logic              inta,
  input  logic              intr_type_valid,
  input  logic [TYPE_W-1:0] intr_type,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] new_sp,
  output logic [DATA_W-1:0] new_cs,
  output logic [DATA_W-1:0] new_ip,
  output logic [DATA_W-1:0] new_flags
);
  localparam int VEC_W = TYPE_W + 2;
  localparam logic [DATA_W-1:0] CLR_MASK =
    ~((DATA_W'(1) << IE_BIT) | (DATA_W'(1) << TR_BIT));

  st_e               st;
  logic [DATA_W-1:0] sp_r, ss_r, cs_r, ip_r, flg_r;
  logic [TYPE_W-1:0] typ_r;
  logic [DATA_W-1:0] sp_dec;
  logic [ADDR_W-1:0] seg_base, stack_addr, vec_base;
  logic              accept;

  assign sp_dec     = sp_r - DATA_W'(2);
  assign seg_base   = ADDR_W'({ss_r, {SEG_SHIFT{1'b0}}});
  assign stack_addr = seg_base + ADDR_W'(sp_dec);
  assign vec_base   = ADDR_W'({typ_r, 2'b00});
  assign take       = (st == ST_IDLE) && boundary && (src != SRC_NONE);
  assign accept     = mem_valid && mem_ready;

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = vec_base;
    mem_wdata = '0;
    case (st)
      ST_PUSH_F:  begin mem_valid = 1'b1; mem_we = 1'b1; mem_addr = stack_addr; mem_wdata = flg_r; end
      ST_PUSH_CS: begin mem_valid = 1'b1; mem_we = 1'b1; mem_addr = stack_addr; mem_wdata = cs_r;  end
      ST_PUSH_IP: begin mem_valid = 1'b1; mem_we = 1'b1; mem_addr = stack_addr; mem_wdata = ip_r;  end
      ST_RD_IP:   begin mem_valid = 1'b1; mem_addr = vec_base; end
      ST_RD_CS:   begin mem_valid = 1'b1; mem_addr = vec_base + ADDR_W'(2); end
      default: ;
    endcase
  end

  assign inta   = (st == ST_ACK);
  assign busy   = (st != ST_IDLE);
  assign done   = (st == ST_DONE);
  assign new_sp = sp_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sp_r      <= '0;
      ss_r      <= '0;
      cs_r      <= '0;
      ip_r      <= '0;
      flg_r     <= '0;
      typ_r     <= '0;
      new_cs    <= '0;
      new_ip    <= '0;
      new_flags <= '0;
    end else begin
      case (st)
        ST_IDLE: if (take) begin
          sp_r  <= sp_in;
          ss_r  <= ss_in;
          cs_r  <= cs_in;
          ip_r  <= ip_in;
          flg_r <= flags_in;
          typ_r <= src_type;
          st    <= (src == SRC_INTR) ? ST_ACK : ST_PUSH_F;
        end
        ST_ACK: if (intr_type_valid) begin
          typ_r <= intr_type;
          st    <= ST_PUSH_F;
        end
        ST_PUSH_F: if (accept) begin
          sp_r      <= sp_dec;
          new_flags <= flg_r & CLR_MASK;
          st        <= ST_PUSH_CS;
        end
        ST_PUSH_CS: if (accept) begin
          sp_r <= sp_dec;
          st   <= ST_PUSH_IP;
        end
        ST_PUSH_IP: if (accept) begin
          sp_r <= sp_dec;
          st   <= ST_RD_IP;
        end
        ST_RD_IP: if (accept) st <= ST_W_IP;
        ST_W_IP: if (mem_rsp_valid) begin
          new_ip <= mem_rdata;
          st     <= ST_RD_CS;
        end
        ST_RD_CS: if (accept) st <= ST_W_CS;
        ST_W_CS: if (mem_rsp_valid) begin
          new_cs <= mem_rdata;
          st     <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: a stalled request keeps its contents
  a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));
  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: no memory traffic while waiting for the requester's type
  a_r8_quiet_ack: assert property (@(posedge clk) disable iff (!rst_n)
    inta |-> !mem_valid);
  // R3: an acknowledge only follows a frame taken with interrupts enabled
  a_r3_ack_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    inta |-> flg_r[IE_BIT]);
  // R6: vector reads stay inside the table
  a_r6_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we) |-> (mem_addr >> VEC_W) == '0);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int TYPE_W    = 8,
  parameter int SEG_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              div_fault,
  input  logic              swi_req,
  input  logic [TYPE_W-1:0] swi_type,
  input  logic              nmi,
  input  logic              intr,
  output logic              inta,
  input  logic              intr_type_valid,
  input  logic [TYPE_W-1:0] intr_type,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] ss_in,
  input  logic [DATA_W-1:0] cs_in,
  input  logic [DATA_W-1:0] ip_in,
  input  logic [DATA_W-1:0] flags_in,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] new_sp,
  output logic [DATA_W-1:0] new_cs,
  output logic [DATA_W-1:0] new_ip,
  output logic [DATA_W-1:0] new_flags
);
  src_e              src;
  logic [TYPE_W-1:0] src_type;
  logic              nmi_pend;
  logic              take;

  irq_nmi_latch u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .nmi_in  (nmi),
    .take    (take && (src == SRC_NMI)),
    .pending (nmi_pend)
  );

  irq_arbiter #(.TYPE_W(TYPE_W)) u_arb (
    .div_fault (div_fault),
    .swi_req   (swi_req),
    .swi_type  (swi_type),
    .nmi_pend  (nmi_pend),
    .intr      (intr),
    .ie_flag   (flags_in[IE_BIT]),
    .tr_flag   (flags_in[TR_BIT]),
    .src       (src),
    .src_type  (src_type)
  );

  irq_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TYPE_W(TYPE_W), .SEG_SHIFT(SEG_SHIFT)
  ) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .boundary        (boundary),
    .src             (src),
    .src_type        (src_type),
    .sp_in           (sp_in),
    .ss_in           (ss_in),
    .cs_in           (cs_in),
    .ip_in           (ip_in),
    .flags_in        (flags_in),
    .take            (take),
    .inta            (inta),
    .intr_type_valid (intr_type_valid),
    .intr_type       (intr_type),
    .mem_valid       (mem_valid),
    .mem_ready       (mem_ready),
    .mem_we          (mem_we),
    .mem_addr        (mem_addr),
    .mem_wdata       (mem_wdata),
    .mem_rsp_valid   (mem_rsp_valid),
    .mem_rdata       (mem_rdata),
    .busy            (busy),
    .done            (done),
    .new_sp          (new_sp),
    .new_cs          (new_cs),
    .new_ip          (new_ip),
    .new_flags       (new_flags)
  );

  // R1: an entry only begins at an instruction boundary
  a_r1_start_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(boundary));
endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  typedef struct packed {
    logic        fault;
    logic        swi;
    logic [7:0]  swt;
    logic        nmi;
    logic        intr;
    logic [7:0]  ityp;
    logic [15:0] flg;
    logic [15:0] sp;
    logic [15:0] ss;
    logic [15:0] cs;
    logic [15:0] ip;
    logic        tk;
    logic [7:0]  et;
    logic        bp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{1'b1,1'b0,8'h00,1'b0,1'b0,8'h00,16'h0300,16'h0100,16'h2000,16'h1111,16'h2222,1'b1,8'h00,1'b0},
    '{1'b0,1'b1,8'h21,1'b0,1'b0,8'h00,16'h0200,16'h0200,16'h3000,16'h4444,16'h5555,1'b1,8'h21,1'b1},
    '{1'b0,1'b1,8'h03,1'b1,1'b1,8'h30,16'h0200,16'h0400,16'h1000,16'h0ABC,16'h0DEF,1'b1,8'h03,1'b0},
    '{1'b0,1'b0,8'h00,1'b1,1'b1,8'h31,16'h0200,16'h0800,16'h1234,16'h6666,16'h7777,1'b1,8'h02,1'b1},
    '{1'b0,1'b0,8'h00,1'b0,1'b1,8'h08,16'h0300,16'h1000,16'h0500,16'h8888,16'h9999,1'b1,8'h08,1'b1},
    '{1'b0,1'b0,8'h00,1'b0,1'b1,8'h09,16'h0100,16'h2000,16'h0600,16'hAAAA,16'hBBBB,1'b1,8'h01,1'b0},
    '{1'b0,1'b0,8'h00,1'b0,1'b1,8'h0A,16'h00C5,16'h3000,16'h0700,16'hCCCC,16'hDDDD,1'b0,8'h00,1'b0},
    '{1'b1,1'b1,8'h40,1'b0,1'b0,8'h00,16'h0000,16'h4000,16'h0800,16'h1357,16'h2468,1'b1,8'h00,1'b1},
    '{1'b0,1'b1,8'hFF,1'b0,1'b0,8'h00,16'h0001,16'h0004,16'hFFFF,16'hFACE,16'hBEEF,1'b1,8'hFF,1'b0},
    '{1'b0,1'b0,8'h00,1'b1,1'b0,8'h00,16'hFFFF,16'h5000,16'h0900,16'h0F0F,16'hF0F0,1'b1,8'h02,1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boundary = 1'b0, div_fault = 1'b0, swi_req = 1'b0, nmi = 1'b0, intr = 1'b0;
  logic [7:0]  swi_type = 8'h0, intr_type = 8'h0;
  logic        intr_type_valid = 1'b0;
  logic [15:0] sp_in = 16'h0, ss_in = 16'h0, cs_in = 16'h0, ip_in = 16'h0, flags_in = 16'h0;
  logic        mem_ready = 1'b1, bp_en = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rdata = 16'h0;
  logic        inta, mem_valid, mem_we, busy, done;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, new_sp, new_cs, new_ip, new_flags;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int wcnt = 0, rcnt = 0, acnt = 0;
  logic [19:0] wa [64];
  logic [15:0] wd [64];
  logic [19:0] ra [64];

  always #5 clk = ~clk;

  irq_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .div_fault(div_fault),
    .swi_req(swi_req), .swi_type(swi_type), .nmi(nmi), .intr(intr), .inta(inta),
    .intr_type_valid(intr_type_valid), .intr_type(intr_type),
    .sp_in(sp_in), .ss_in(ss_in), .cs_in(cs_in), .ip_in(ip_in), .flags_in(flags_in),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .new_sp(new_sp), .new_cs(new_cs), .new_ip(new_ip),
    .new_flags(new_flags)
  );

  function automatic logic [15:0] vword(input logic [19:0] a);
    return a[15:0] ^ 16'hC35A;
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    intr_type_valid <= inta && !intr_type_valid;
    if (inta) acnt <= acnt + 1;
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        wa[wcnt % 64] <= mem_addr;
        wd[wcnt % 64] <= mem_wdata;
        wcnt <= wcnt + 1;
      end else begin
        ra[rcnt % 64] <= mem_addr;
        rcnt <= rcnt + 1;
        mem_rsp_valid <= 1'b1;
        mem_rdata <= vword(mem_addr);
      end
    end
  end

  always @(negedge clk) mem_ready <= bp_en ? ~mem_ready : 1'b1;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
        summary();
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 200 && !seen; k++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
  endtask

  task automatic pulse_boundary();
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    div_fault = 1'b0;
    swi_req = 1'b0;
  endtask

  task automatic check_frame(input logic [15:0] sp, ss, cs, ip, flg,
                             input logic [7:0] t, input int wb, rb);
    logic [15:0] s1, s2, s3;
    s1 = sp - 16'd2; s2 = sp - 16'd4; s3 = sp - 16'd6;
    chk(wcnt - wb == 3, "R4 write count", 32'(wcnt - wb), 32'd3);
    chk(wa[wb % 64] == phys(ss, s1) && wd[wb % 64] == flg, "R4 flags push",
        {wa[wb % 64][15:0], wd[wb % 64]}, {phys(ss, s1)[15:0], flg});
    chk(wa[(wb+1) % 64] == phys(ss, s2) && wd[(wb+1) % 64] == cs, "R4 CS push",
        {wa[(wb+1) % 64][15:0], wd[(wb+1) % 64]}, {phys(ss, s2)[15:0], cs});
    chk(wa[(wb+2) % 64] == phys(ss, s3) && wd[(wb+2) % 64] == ip, "R4 IP push",
        {wa[(wb+2) % 64][15:0], wd[(wb+2) % 64]}, {phys(ss, s3)[15:0], ip});
    chk(ra[rb % 64] == {10'h0, t, 2'b00} && ra[(rb+1) % 64] == {10'h0, t, 2'b10},
        "R2 R6 R7 vector addresses", {ra[rb % 64][15:0], ra[(rb+1) % 64][15:0]},
        {6'h0, t, 2'b00, 6'h0, t, 2'b10});
    chk(new_ip == vword({10'h0, t, 2'b00}) && new_cs == vword({10'h0, t, 2'b10}),
        "R6 new IP/CS", {new_ip, new_cs}, {vword({10'h0, t, 2'b00}), vword({10'h0, t, 2'b10})});
    chk(new_sp == s3, "R11 new SP", 32'(new_sp), 32'(s3));
    chk(new_flags == (flg & 16'hFCFF), "R5 new flags", 32'(new_flags), 32'(flg & 16'hFCFF));
  endtask

  initial begin
    bit seen;
    int wb, rb, ab;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !inta && !mem_valid, "R12 reset outputs",
        {busy, done, inta, mem_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VT[i];
      bp_en = v.bp;
      sp_in = v.sp; ss_in = v.ss; cs_in = v.cs; ip_in = v.ip; flags_in = v.flg;
      intr_type = v.ityp;
      intr = v.intr;
      nmi = v.nmi;
      @(negedge clk);
      nmi = 1'b0;
      div_fault = v.fault; swi_req = v.swi; swi_type = v.swt;
      wb = wcnt; rb = rcnt; ab = acnt;
      pulse_boundary();
      if (v.tk) begin
        wait_done(seen);
        chk(seen, "R11 done seen", 32'(seen), 32'd1);
        check_frame(v.sp, v.ss, v.cs, v.ip, v.flg, v.et, wb, rb);
        chk((acnt != ab) == (v.intr && v.flg[9] && !v.fault && !v.swi && !v.nmi),
            "R8 acknowledge use", 32'(acnt - ab), 32'(v.intr && v.flg[9]));
        @(negedge clk);
        chk(!done && !busy, "R11 done single cycle", {done, busy}, 32'h0);
      end else begin
        repeat (20) @(negedge clk);
        chk(wcnt == wb && acnt == ab && !busy, "R3 masked request ignored",
            32'(wcnt - wb + acnt - ab), 32'd0);
      end
      intr = 1'b0;
      repeat (2) @(negedge clk);
    end

    // R1: sources present without a boundary do nothing
    bp_en = 1'b0;
    flags_in = 16'h0200; sp_in = 16'h0600; ss_in = 16'h0; cs_in = 16'h1; ip_in = 16'h2;
    div_fault = 1'b1; intr = 1'b1;
    wb = wcnt; ab = acnt;
    repeat (10) @(negedge clk);
    chk(wcnt == wb && acnt == ab && !busy, "R1 no boundary no entry",
        32'(wcnt - wb + acnt - ab), 32'd0);
    div_fault = 1'b0; intr = 1'b0;
    @(negedge clk);

    // R9: NMI pulse during a busy entry is serviced at the next boundary
    flags_in = 16'h0000;
    div_fault = 1'b1;
    pulse_boundary();
    @(negedge clk);
    nmi = 1'b1;
    @(negedge clk);
    nmi = 1'b0;
    wait_done(seen);
    chk(seen, "R9 first entry done", 32'(seen), 32'd1);
    @(negedge clk);
    wb = wcnt; rb = rcnt;
    nmi = 1'b1;              // held level; its rising edge was already consumed? no: new edge here
    @(negedge clk);
    nmi = 1'b0;
    @(negedge clk);
    pulse_boundary();
    wait_done(seen);
    chk(seen && ra[rb % 64] == 20'h00008, "R9 latched NMI taken", 32'(ra[rb % 64]), 32'h8);
    @(negedge clk);
    // level held high: one entry only
    nmi = 1'b1;
    @(negedge clk);
    rb = rcnt;
    pulse_boundary();
    wait_done(seen);
    chk(seen && ra[rb % 64] == 20'h00008, "R9 held level first entry", 32'(ra[rb % 64]), 32'h8);
    @(negedge clk);
    wb = wcnt;
    pulse_boundary();
    repeat (20) @(negedge clk);
    chk(wcnt == wb && !busy, "R9 held level no second entry", 32'(wcnt - wb), 32'd0);
    nmi = 1'b0;
    @(negedge clk);

    // R10: heavy back-pressure on a software interrupt with stack wrap
    bp_en = 1'b1;
    sp_in = 16'h0002; ss_in = 16'h0010; cs_in = 16'h7E7E; ip_in = 16'h8181; flags_in = 16'h0300;
    swi_req = 1'b1; swi_type = 8'h80;
    wb = wcnt; rb = rcnt;
    pulse_boundary();
    wait_done(seen);
    chk(seen, "R10 done under stalls", 32'(seen), 32'd1);
    check_frame(16'h0002, 16'h0010, 16'h7E7E, 16'h8181, 16'h0300, 8'h80, wb, rb);
    bp_en = 1'b0;
    repeat (2) @(negedge clk);
    summary();
  end
endmodule